// File: doc/BRIEF.md
# Hitless Switching Bandwidth Sequencer

This block steers a clock PLL through a reference disturbance without a phase hit at the output. Once the loop has shown lock, a rising loss-of-lock indication starts a fixed recovery run. The block first gates off the main phase detector and forces the loop into narrow bandwidth. It can then ask an external delay element to shift the feedback edge by whole oscillator cycles to line it up with the new reference. After that it turns the detector back on and waits for a run of consecutive in-window phase comparisons. A timer then runs, and when it expires the block drops the narrow-bandwidth override and arms itself again.

The trigger is the loss-of-lock edge alone. It works the same whether the reference mux is switched automatically or by hand, and whether the switch happens inside or upstream of the PLL. The effective loop-bandwidth control is the OR of the external narrow-bandwidth pin and the internal override. The override therefore only has an effect while the pin asks for wide bandwidth. All control and status pins are plain levels. The build-out step uses a request/done handshake: the request is held until done is sampled high.

Parameters: `PBO_EN` (build-out step present, default 1), `RUN_LEN` (consecutive in-window comparisons needed, default 8), `WIDE_CYCLES` (wide-bandwidth timer length in clock cycles, default 18).

Top module: `hitless_bw_seq`

## Requirements
- R1: After reset, pd_en_o is 1, nbw_override_o is 0, pbo_req_o is 0 and loop_narrow_o equals nbw_pin_i.
- R2: Until lol_i has been sampled 0 at least once after reset, the block is unarmed: lol_i held at 1 does not disable the detector or raise the override.
- R3: When armed, a 0-to-1 change of lol_i sampled at a clock edge makes pd_en_o 0 and nbw_override_o 1 immediately after that edge.
- R4: loop_narrow_o is 1 whenever nbw_pin_i is 1 or nbw_override_o is 1, and equals nbw_pin_i otherwise.
- R5: With PBO_EN=1, pbo_req_o rises one cycle after the trigger edge and stays 1, with pd_en_o 0, until pbo_done_i is sampled 1.
- R6: The edge that samples pbo_done_i=1 while pbo_req_o=1 makes pbo_req_o 0 and pd_en_o 1 right after it. With PBO_EN=0, pd_en_o returns to 1 one cycle after the trigger edge.
- R7: Qualification counts cycles with cmp_valid_i=1 and cmp_hit_i=1. RUN_LEN (8) such cycles in a row complete it. A cycle with cmp_valid_i=1 and cmp_hit_i=0 resets the run to zero. Cycles with cmp_valid_i=0 neither add to nor reset the run.
- R8: nbw_override_o falls at the WIDE_CYCLES-th clock edge after the edge that samples the completing comparison. Comparisons sampled in that interval have no effect.
- R9: After the override falls the block is armed again, and a new 0-to-1 change of lol_i restarts the sequence.
- R10: A 0-to-1 change of lol_i during a running sequence (after the build-out step) does not restart it: pbo_req_o stays 0 and pd_en_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lol_i | input | 1 | Loss-of-lock indication, 1 = unlocked |
| nbw_pin_i | input | 1 | External narrow-bandwidth select, 1 = narrow |
| cmp_valid_i | input | 1 | One phase comparison result is present this cycle |
| cmp_hit_i | input | 1 | The comparison lies inside the lock window (about 2 ns) |
| pbo_done_i | input | 1 | Build-out adjustment finished |
| pd_en_o | output | 1 | Main phase detector enable |
| nbw_override_o | output | 1 | Internal narrow-bandwidth override |
| loop_narrow_o | output | 1 | Effective narrow-bandwidth control to the loop |
| pbo_req_o | output | 1 | Build-out request, held until done |

## Verification
The qualification logic is driven with comparison streams that differ in where the misses fall. These include an unbroken run, a miss one short of the run, a run that starts late, a run that starts after an early miss, a stream with gaps in cmp_valid_i, and a stream with no hits. They separate a counter that resets on a miss from one that only pauses, and one that resets on idle cycles from one that correctly holds. The measured fall of the override gives the exact timer length after the completing edge. Directed runs cover arming, the handshake hold, a retrigger in mid-sequence and re-arming.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
  typedef enum logic [2:0] {
    ST_UNARMED = 3'd0,
    ST_ARMED   = 3'd1,
    ST_HOLD    = 3'd2,
    ST_BUILD   = 3'd3,
    ST_QUAL    = 3'd4,
    ST_TIMER   = 3'd5
  } hs_state_e;
endpackage

// File: rtl/hs_lol_edge.sv
module hs_lol_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lol_i,
  output logic rise_o
);
  logic lol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lol_q <= 1'b0;
    else        lol_q <= lol_i;
  end

  assign rise_o = lol_i & ~lol_q;
endmodule

// File: rtl/hs_run_qual.sv
module hs_run_qual #(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic valid_i,
  input  logic hit_i,
  output logic done_o
);
  localparam int QW = $clog2(RUN_LEN + 1);
  localparam logic [QW-1:0] LAST = QW'(RUN_LEN - 1);

  logic [QW-1:0] cnt;

  assign done_o = ~clear_i & valid_i & hit_i & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) cnt <= '0;
    else if (valid_i) begin
      if (!hit_i || done_o) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
    end
  end

  // R7: a miss wipes the run
  a_r7_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !hit_i) |=> (cnt == '0));

  // R7: idle comparison slots hold the run
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !valid_i) |=> $stable(cnt));
endmodule

// File: rtl/hs_wide_timer.sv
module hs_wide_timer #(
  parameter int CYCLES = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int TW = $clog2(CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(CYCLES - 1);

  logic [TW-1:0] cnt;

  assign expire_o = run_i & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i || expire_o) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  // R8: the timer advances by one per running cycle until expiry
  a_r8_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !expire_o) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/hitless_bw_seq.sv
module hitless_bw_seq
  import hs_seq_pkg::*;
#(
  parameter bit PBO_EN      = 1'b1,
  parameter int RUN_LEN     = 8,
  parameter int WIDE_CYCLES = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lol_i,
  input  logic nbw_pin_i,
  input  logic cmp_valid_i,
  input  logic cmp_hit_i,
  input  logic pbo_done_i,
  output logic pd_en_o,
  output logic nbw_override_o,
  output logic loop_narrow_o,
  output logic pbo_req_o
);
  hs_state_e st, st_nx;
  logic lol_rise, qual_done, timer_exp;

  hs_lol_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lol_i  (lol_i),
    .rise_o (lol_rise)
  );

  hs_run_qual #(.RUN_LEN(RUN_LEN)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (st != ST_QUAL),
    .valid_i (cmp_valid_i),
    .hit_i   (cmp_hit_i),
    .done_o  (qual_done)
  );

  hs_wide_timer #(.CYCLES(WIDE_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (st == ST_TIMER),
    .expire_o (timer_exp)
  );

  // State after the detector-off cycle depends on the build-out option
  localparam hs_state_e ST_AFTER_HOLD = PBO_EN ? ST_BUILD : ST_QUAL;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_UNARMED: if (!lol_i)     st_nx = ST_ARMED;
      ST_ARMED:   if (lol_rise)   st_nx = ST_HOLD;
      ST_HOLD:                    st_nx = ST_AFTER_HOLD;
      ST_BUILD:   if (pbo_done_i) st_nx = ST_QUAL;
      ST_QUAL:    if (qual_done)  st_nx = ST_TIMER;
      ST_TIMER:   if (timer_exp)  st_nx = ST_ARMED;
      default:                    st_nx = ST_UNARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_UNARMED;
    else        st <= st_nx;
  end

  assign pd_en_o        = (st != ST_HOLD) && (st != ST_BUILD);
  assign nbw_override_o = (st == ST_HOLD) || (st == ST_BUILD) ||
                          (st == ST_QUAL) || (st == ST_TIMER);
  assign pbo_req_o      = (st == ST_BUILD);
  assign loop_narrow_o  = nbw_pin_i | nbw_override_o;

  // R3: an armed loss-of-lock rise gates the detector and forces narrow
  a_r3_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARMED && lol_rise) |=> (!pd_en_o && nbw_override_o));

  // R2: nothing is forced while unarmed
  a_r2_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_UNARMED) |=> !nbw_override_o);

  // R5: the build-out request holds until done
  a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pbo_req_o && !pbo_done_i) |=> (pbo_req_o && !pd_en_o));

  // R6: done brings the detector back
  a_r6_pd_back: assert property (@(posedge clk) disable iff (!rst_n)
    (pbo_req_o && pbo_done_i) |=> (pd_en_o && !pbo_req_o));

  // R10: no restart once the detector is back in a running sequence
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (nbw_override_o && pd_en_o) |=> !pbo_req_o);
endmodule

// File: tb/hitless_bw_seq_test.sv
module hitless_bw_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WBW        = 18;
  localparam int NV         = 7;
  localparam int NPAT       = 12;
  localparam int NSTEP      = 42;

  // {valid[11:0], hit[11:0], completing edge index (FF = never)}, bit 0 first
  localparam logic [31:0] VEC [NV] = '{
    {12'hFFF, 12'hFFF, 8'd7},
    {12'hFFF, 12'hF7F, 8'hFF},
    {12'hFFF, 12'hFF0, 8'd11},
    {12'hFFF, 12'hEFE, 8'hFF},
    {12'hFFF, 12'h1FE, 8'd8},
    {12'h78F, 12'h78F, 8'd10},
    {12'hFFF, 12'h000, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lol = 1'b0, pin = 1'b0, cv = 1'b0, ch = 1'b0, done = 1'b0;
  logic pd_en, ovr, narrow, req;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hitless_bw_seq #(.PBO_EN(1'b1), .RUN_LEN(8), .WIDE_CYCLES(WBW)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .lol_i          (lol),
    .nbw_pin_i      (pin),
    .cmp_valid_i    (cv),
    .cmp_hit_i      (ch),
    .pbo_done_i     (done),
    .pd_en_o        (pd_en),
    .nbw_override_o (ovr),
    .loop_narrow_o  (narrow),
    .pbo_req_o      (req)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic lol_level);
    rst_n = 1'b0; lol = lol_level; pin = 1'b0; cv = 1'b0; ch = 1'b0; done = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int drop;
    int exp_drop;
    tick();

    // Table walk: qualification patterns (R7) and timer length (R8)
    for (int v = 0; v < NV; v++) begin
      do_reset(1'b0);
      tick(); tick();
      lol = 1'b1;
      tick();
      check("R3 pd_en after trigger", pd_en, 0);
      for (int w = 0; w < 5 && !req; w++) tick();
      done = 1'b1;
      tick();
      done = 1'b0;
      drop = -1;
      for (int e = 0; e < NSTEP; e++) begin
        cv = (e < NPAT) ? VEC[v][20 + e] : 1'b0;
        ch = (e < NPAT) ? VEC[v][8 + e]  : 1'b0;
        tick();
        if (!ovr && drop < 0) drop = e;
      end
      cv = 1'b0; ch = 1'b0;
      exp_drop = (VEC[v][7:0] == 8'hFF) ? -1 : int'(VEC[v][7:0]) + WBW;
      check($sformatf("R7/R8 vector %0d override fall edge", v), drop, exp_drop);
    end

    // R1 and R2: reset with lol held high
    do_reset(1'b1);
    tick();
    check("R1 pd_en reset", pd_en, 1);
    check("R1 override reset", ovr, 0);
    check("R1 pbo_req reset", req, 0);
    check("R1 loop_narrow reset", narrow, 0);
    tick(); tick(); tick();
    check("R2 unarmed pd_en", pd_en, 1);
    check("R2 unarmed override", ovr, 0);

    // Arm, then trigger (R3, R4)
    lol = 1'b0; tick();
    lol = 1'b1; tick();
    check("R3 pd_en off", pd_en, 0);
    check("R3 override on", ovr, 1);
    check("R4 narrow from override", narrow, 1);

    // R5: request held while done is low
    tick();
    check("R5 pbo_req up", req, 1);
    tick(); tick(); tick();
    check("R5 pbo_req held", req, 1);
    check("R5 pd_en off during build-out", pd_en, 0);
    pin = 1'b1;
    #1;
    check("R4 narrow pin and override", narrow, 1);
    pin = 1'b0;

    // R6: done returns the detector
    done = 1'b1; tick(); done = 1'b0;
    check("R6 pd_en back", pd_en, 1);
    check("R6 pbo_req dropped", req, 0);

    // R10: retrigger inside the sequence
    lol = 1'b0; tick();
    lol = 1'b1; tick();
    check("R10 no new request", req, 0);
    check("R10 pd_en stays", pd_en, 1);
    tick();
    check("R10 no new request later", req, 0);

    // R8: eight hits then measure timer
    for (int i = 0; i < 8; i++) begin
      cv = 1'b1; ch = 1'b1; tick();
    end
    cv = 1'b0; ch = 1'b0;
    drop = -1;
    for (int e = 1; e < 40; e++) begin
      tick();
      if (!ovr && drop < 0) drop = e;
    end
    check("R8 edges after completing comparison", drop, WBW);
    check("R4 narrow follows pin low", narrow, 0);
    pin = 1'b1;
    #1;
    check("R4 narrow follows pin high", narrow, 1);
    pin = 1'b0;

    // R9: re-armed, new rise restarts
    lol = 1'b0; tick();
    lol = 1'b1; tick();
    check("R9 retrigger pd_en off", pd_en, 0);
    check("R9 retrigger override", ovr, 1);
    tick();
    check("R9 retrigger request", req, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule